// File: doc/BRIEF.md
# Boot Image Loader with Bad-Block Skipping

This block runs at boot and copies an image of a given byte length out of NAND flash into destination memory. It walks the flash one erase block at a time and, inside each block, one page at a time. Each page goes through a request/acknowledge handshake to a page reader. The page reader moves the page data to the destination address given with the request. It then returns whether the page was readable and what its first spare bytes hold.

A block is judged only after its pages have been read. If a readable page carries a non-blank marker in its spare bytes, the block is bad. A block with no readable page at all is also bad. A bad block is skipped and does not count against the image length, and the loader moves on to the next block. An unreadable page in a block that is not bad ends the load with a fatal pulse. The destination commit pointer moves past a block only once that block has been judged good. Data written from a bad block is therefore overwritten by the next good block. When no image blocks remain, a done pulse is raised and the loader returns to idle.

Top module: `nand_image_loader`

## Requirements
- R1: On `start` the first page requested is `start_offset` divided by the page size, and its destination is `dst_base`.
- R2: Each block reads at most `PAGES_PER_BLK` pages. The count is the smaller of that limit and the remaining image pages, so the final block reads fewer. The remaining image pages are the image bytes divided by the page size, rounded up.
- R3: A page answered readable (`rd_ok`=1) whose spare byte 0 (`rd_spare[7:0]`) or spare byte 1 (`rd_spare[15:8]`) differs from 0xFF marks its block bad. No further page of that block is requested.
- R4: A block in which no requested page was readable is skipped as bad.
- R5: An unreadable page in a block that ends up neither marked nor fully unreadable raises `fatal` for one cycle. The loader then returns to idle without raising `done`.
- R6: Every judged block moves the flash position on by `PAGES_PER_BLK` pages from where that block started, whether the block is good or bad. Bad blocks leave the remaining byte, page and block counts unchanged.
- R7: `commit_addr` takes `dst_base` on start. It then advances only after a block is judged good, by the smaller of the remaining bytes and one block's bytes. It never changes while a page request is outstanding.
- R8: `done` pulses for one cycle when the remaining block count reaches zero. An image size of zero gives `done` with no page request. `done` and `fatal` never pulse together.
- R9: `rd_req`, `rd_page` and `rd_dst` hold until `rd_ack`. Within a block, page k goes to the block's committed destination plus k times the page size.
- R10: After reset the loader is idle, with `rd_req`, `done` and `fatal` low and `commit_addr` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (taken while idle) |
| start_offset | input | ADDR_W | Flash byte offset of the image |
| image_bytes | input | SIZE_W | Image length in bytes |
| dst_base | input | ADDR_W | Destination base address |
| rd_req | output | 1 | Page read request, held until acknowledged |
| rd_page | output | PAGE_W | Flash page index of the request |
| rd_dst | output | ADDR_W | Destination address for the page data |
| rd_ack | input | 1 | Page reader response valid |
| rd_ok | input | 1 | Page was readable (correctable) |
| rd_spare | input | 8*MARK_BYTES | First spare bytes, byte 0 in the low bits |
| commit_addr | output | ADDR_W | Destination address committed by good blocks |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse: image fully loaded |
| fatal | output | 1 | One-cycle pulse: unrecoverable read error |

## Verification
The bench builds the loader with 16-byte pages and 4-page blocks. With that geometry, offsets that are not block-aligned, short final blocks, markers early and late in a block, and whole-block skips all fit in a few dozen pages. A behavioural model works out the expected sequence of page requests and commit values from per-page flash attributes. The page reader answers with latencies that vary by page, so holding and stepping requests is exercised. Scenarios cover a clean multi-block load, skips caused by either marker byte, an unreadable block, an unreadable page followed by a marker, a fatal stop and a zero-length image.

// File: rtl/nil_pkg.sv
package nil_pkg;
   typedef enum logic [2:0] {
      LD_IDLE,
      LD_SETUP,
      LD_READ,
      LD_STEP,
      LD_JUDGE
   } ld_state_t;
endpackage

// File: rtl/nil_span_calc.sv
module nil_span_calc #(
   parameter int SIZE_W = 32,
   parameter int SH     = 11
) (
   input  logic [SIZE_W-1:0] amount,
   output logic [SIZE_W:0]   units
);
   generate
      if (SH == 0) begin : g_unit
         assign units = {1'b0, amount};
      end else begin : g_round
         logic [SIZE_W:0] biased;
         assign biased = {1'b0, amount} + (SIZE_W+1)'((1 << SH) - 1);
         assign units  = biased >> SH;
      end
   endgenerate
endmodule

// File: rtl/nil_marker_check.sv
module nil_marker_check #(
   parameter int MARK_BYTES = 2
) (
   input  logic [8*MARK_BYTES-1:0] spare,
   output logic                    marked
);
   logic [MARK_BYTES-1:0] hit;
   generate
      for (genvar i = 0; i < MARK_BYTES; i++) begin : g_byte
         assign hit[i] = (spare[8*i +: 8] != 8'hFF);
      end
   endgenerate
   assign marked = |hit;
endmodule

// File: rtl/nand_image_loader.sv
module nand_image_loader
   import nil_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int SIZE_W        = 32,
   parameter int PAGE_W        = 24,
   parameter int PAGE_BYTES    = 2048,
   parameter int PAGES_PER_BLK = 64,
   parameter int MARK_BYTES    = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [ADDR_W-1:0]       start_offset,
   input  logic [SIZE_W-1:0]       image_bytes,
   input  logic [ADDR_W-1:0]       dst_base,
   output logic                    rd_req,
   output logic [PAGE_W-1:0]       rd_page,
   output logic [ADDR_W-1:0]       rd_dst,
   input  logic                    rd_ack,
   input  logic                    rd_ok,
   input  logic [8*MARK_BYTES-1:0] rd_spare,
   output logic [ADDR_W-1:0]       commit_addr,
   output logic                    busy,
   output logic                    done,
   output logic                    fatal
);
   localparam int PG_SH     = $clog2(PAGE_BYTES);
   localparam int BLK_SH    = PG_SH + $clog2(PAGES_PER_BLK);
   localparam int BLK_BYTES = PAGE_BYTES * PAGES_PER_BLK;
   localparam int CNT_W     = $clog2(PAGES_PER_BLK + 1);

   generate
      if ((1 << PG_SH) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if ((1 << $clog2(PAGES_PER_BLK)) != PAGES_PER_BLK) begin : g_bad_blk
         $error("PAGES_PER_BLK must be a power of two");
      end
      if (BLK_SH >= SIZE_W) begin : g_bad_size
         $error("SIZE_W too narrow for one block");
      end
      if (PAGE_W > ADDR_W || MARK_BYTES < 1) begin : g_bad_misc
         $error("PAGE_W or MARK_BYTES out of range");
      end
   endgenerate

   ld_state_t          state;
   logic [SIZE_W-1:0]  bytes_left;
   logic [SIZE_W:0]    pages_left;
   logic [SIZE_W:0]    blocks_left;
   logic [PAGE_W-1:0]  page_pos;
   logic [PAGE_W-1:0]  blk_page;
   logic [ADDR_W-1:0]  blk_dst;
   logic [CNT_W-1:0]   blk_pages;
   logic [CNT_W-1:0]   blk_left;
   logic               seen_good, seen_bad, seen_err;
   logic               done_q, fatal_q;

   logic [SIZE_W:0]    start_pages, start_blocks;
   logic               marked;
   logic [ADDR_W-1:0]  offs_page;
   logic [SIZE_W-1:0]  blk_bytes;
   logic [CNT_W-1:0]   blk_cap;
   logic               take, skip_blk;

   nil_span_calc #(.SIZE_W(SIZE_W), .SH(PG_SH)) u_pages (
      .amount(image_bytes), .units(start_pages));
   nil_span_calc #(.SIZE_W(SIZE_W), .SH(BLK_SH)) u_blocks (
      .amount(image_bytes), .units(start_blocks));
   nil_marker_check #(.MARK_BYTES(MARK_BYTES)) u_mark (
      .spare(rd_spare), .marked(marked));

   assign offs_page = start_offset >> PG_SH;
   assign blk_bytes = (bytes_left > SIZE_W'(BLK_BYTES)) ? SIZE_W'(BLK_BYTES) : bytes_left;
   assign blk_cap   = (pages_left > (SIZE_W+1)'(PAGES_PER_BLK)) ?
                      CNT_W'(PAGES_PER_BLK) : pages_left[CNT_W-1:0];
   assign take      = (state == LD_READ) && rd_ack;
   assign skip_blk  = seen_bad || !seen_good;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= LD_IDLE;
         bytes_left  <= '0;
         pages_left  <= '0;
         blocks_left <= '0;
         page_pos    <= '0;
         blk_page    <= '0;
         blk_dst     <= '0;
         blk_pages   <= '0;
         blk_left    <= '0;
         seen_good   <= 1'b0;
         seen_bad    <= 1'b0;
         seen_err    <= 1'b0;
         commit_addr <= '0;
         done_q      <= 1'b0;
         fatal_q     <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         fatal_q <= 1'b0;
         unique case (state)
            LD_IDLE: begin
               if (start) begin
                  bytes_left  <= image_bytes;
                  pages_left  <= start_pages;
                  blocks_left <= start_blocks;
                  page_pos    <= offs_page[PAGE_W-1:0];
                  commit_addr <= dst_base;
                  if (start_blocks == '0) done_q <= 1'b1;
                  else                    state  <= LD_SETUP;
               end
            end
            LD_SETUP: begin
               blk_pages <= blk_cap;
               blk_left  <= blk_cap;
               blk_page  <= page_pos;
               blk_dst   <= commit_addr;
               seen_good <= 1'b0;
               seen_bad  <= 1'b0;
               seen_err  <= 1'b0;
               state     <= LD_READ;
            end
            LD_READ: begin
               if (take) begin
                  if (rd_ok) begin
                     seen_good <= 1'b1;
                     if (marked) seen_bad <= 1'b1;
                  end else begin
                     seen_err <= 1'b1;
                  end
                  blk_page <= blk_page + PAGE_W'(1);
                  blk_dst  <= blk_dst + ADDR_W'(PAGE_BYTES);
                  blk_left <= blk_left - CNT_W'(1);
                  if ((rd_ok && marked) || blk_left == CNT_W'(1)) state <= LD_JUDGE;
                  else                                             state <= LD_STEP;
               end
            end
            LD_STEP: state <= LD_READ;
            LD_JUDGE: begin
               if (seen_err && !skip_blk) begin
                  fatal_q <= 1'b1;
                  state   <= LD_IDLE;
               end else begin
                  page_pos <= page_pos + PAGE_W'(PAGES_PER_BLK);
                  if (!skip_blk) begin
                     commit_addr <= commit_addr + ADDR_W'(blk_bytes);
                     bytes_left  <= bytes_left - blk_bytes;
                     pages_left  <= pages_left - (SIZE_W+1)'(blk_pages);
                     blocks_left <= blocks_left - (SIZE_W+1)'(1);
                     if (blocks_left == (SIZE_W+1)'(1)) begin
                        done_q <= 1'b1;
                        state  <= LD_IDLE;
                     end else begin
                        state <= LD_SETUP;
                     end
                  end else begin
                     state <= LD_SETUP;
                  end
               end
            end
            default: state <= LD_IDLE;
         endcase
      end
   end

   assign rd_req  = (state == LD_READ);
   assign rd_page = blk_page;
   assign rd_dst  = blk_dst;
   assign busy    = (state != LD_IDLE);
   assign done    = done_q;
   assign fatal   = fatal_q;

   // R8: the two outcomes are exclusive
   assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fatal}));
   // R8: completion leaves the loader idle
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R5: a fatal stop returns to idle with no request
   assert_fatal_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fatal |-> (!busy && !rd_req));
   // R9: an unanswered request holds its page and destination
   assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_page) && $stable(rd_dst)));
   // R9: an answered request moves on to the following page
   assert_page_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack) |=> (rd_page == $past(rd_page) + PAGE_W'(1)));
   // R7: no commit while a page is outstanding
   assert_commit_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> $stable(commit_addr));
endmodule

// File: tb/tb_nand_image_loader.sv
module tb_nand_image_loader;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int SW = 16;
   localparam int PW = 8;
   localparam int PB = 16;
   localparam int PPB = 4;
   localparam int BB = PB * PPB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_offset = '0;
   logic [SW-1:0] image_bytes = '0;
   logic [AW-1:0] dst_base = '0;
   logic          rd_req;
   logic [PW-1:0] rd_page;
   logic [AW-1:0] rd_dst;
   logic          rd_ack = 1'b0;
   logic          rd_ok = 1'b0;
   logic [15:0]   rd_spare = 16'hFFFF;
   logic [AW-1:0] commit_addr;
   logic          busy, done, fatal;

   int checks = 0;
   int errors = 0;

   bit unread [0:255];
   bit mark0  [0:255];
   bit mark1  [0:255];

   int exp_pg[$];
   int exp_dst[$];
   int exp_commit[$];
   bit exp_fatal;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_image_loader #(
      .ADDR_W(AW), .SIZE_W(SW), .PAGE_W(PW),
      .PAGE_BYTES(PB), .PAGES_PER_BLK(PPB), .MARK_BYTES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset),
      .image_bytes(image_bytes), .dst_base(dst_base),
      .rd_req(rd_req), .rd_page(rd_page), .rd_dst(rd_dst),
      .rd_ack(rd_ack), .rd_ok(rd_ok), .rd_spare(rd_spare),
      .commit_addr(commit_addr), .busy(busy), .done(done), .fatal(fatal)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_flash();
      for (int i = 0; i < 256; i++) begin
         unread[i] = 1'b0; mark0[i] = 1'b0; mark1[i] = 1'b0;
      end
   endtask

   // behavioural reference: expected requests, commits and outcome
   task automatic build_model(input int offs, input int size, input int base);
      int bytes_left, pages_left, blocks_left, page, dst;
      bytes_left  = size;
      pages_left  = (size + PB - 1) / PB;
      blocks_left = (size + BB - 1) / BB;
      page        = offs / PB;
      dst         = base;
      exp_pg.delete(); exp_dst.delete(); exp_commit.delete();
      exp_fatal = 1'b0;
      exp_commit.push_back(base);
      while (blocks_left > 0 && page < 240) begin
         int bp, bb, good, err, pg, d, n;
         bit bad;
         bp = (pages_left > PPB) ? PPB : pages_left;
         bb = (bytes_left > BB) ? BB : bytes_left;
         good = 0; err = 0; bad = 1'b0; pg = page; d = dst; n = bp;
         while (n > 0 && !bad) begin
            exp_pg.push_back(pg);
            exp_dst.push_back(d);
            if (!unread[pg]) begin
               good++;
               if (mark0[pg] || mark1[pg]) bad = 1'b1;
            end else begin
               err++;
            end
            pg++; d += PB; n--;
         end
         if (good == 0) bad = 1'b1;
         if (err > 0 && !bad) begin
            exp_fatal = 1'b1;
            return;
         end
         if (!bad) begin
            dst += bb;
            exp_commit.push_back(dst);
            bytes_left -= bb; pages_left -= bp; blocks_left--;
         end
         page += PPB;
      end
   endtask

   // page reader model: checks each request against the reference
   initial begin
      forever begin
         @(negedge clk);
         if (rd_req) begin
            int pg;
            pg = int'(rd_page);
            if (exp_pg.size() == 0) begin
               check(1'b0, "R2 R3", "unexpected request page", pg, -1);
            end else begin
               check(pg == exp_pg[0], "R1 R2 R3 R6", "request page", pg, exp_pg[0]);
               check(int'(rd_dst) == (exp_dst[0] & 16'hFFFF), "R9", "request destination",
                     int'(rd_dst), exp_dst[0] & 16'hFFFF);
               void'(exp_pg.pop_front());
               void'(exp_dst.pop_front());
            end
            repeat (pg % 3) @(negedge clk);
            rd_ack   = 1'b1;
            rd_ok    = !unread[pg];
            rd_spare = {mark1[pg] ? 8'h00 : 8'hFF, mark0[pg] ? 8'h00 : 8'hFF};
            @(negedge clk);
            rd_ack   = 1'b0;
            rd_ok    = 1'b0;
            rd_spare = 16'hFFFF;
         end
      end
   end

   // commit monitor, every clock
   logic [AW-1:0] prev_commit = '0;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && commit_addr != prev_commit) begin
            if (exp_commit.size() == 0) begin
               check(1'b0, "R7", "unexpected commit", int'(commit_addr), -1);
            end else begin
               check(int'(commit_addr) == (exp_commit[0] & 16'hFFFF), "R7", "commit value",
                     int'(commit_addr), exp_commit[0] & 16'hFFFF);
               void'(exp_commit.pop_front());
            end
            prev_commit = commit_addr;
         end
         if (rst_n) check(!(done && fatal), "R8", "done with fatal", int'(done), 0);
      end
   end

   task automatic run(input string name, input int offs, input int size, input int base);
      int guard;
      bit got_done, got_fatal;
      build_model(offs, size, base);
      @(negedge clk);
      start_offset = AW'(offs);
      image_bytes  = SW'(size);
      dst_base     = AW'(base);
      start        = 1'b1;
      @(negedge clk);
      start = 1'b0;
      guard = 0; got_done = 1'b0; got_fatal = 1'b0;
      while (!got_done && !got_fatal && guard < 5000) begin
         if (done) got_done = 1'b1;
         else if (fatal) got_fatal = 1'b1;
         else begin
            @(negedge clk);
            guard++;
         end
      end
      check(got_fatal == exp_fatal, exp_fatal ? "R5" : "R8", {name, " fatal outcome"},
            int'(got_fatal), int'(exp_fatal));
      check(got_done == !exp_fatal, "R8", {name, " done outcome"},
            int'(got_done), int'(!exp_fatal));
      repeat (3) @(negedge clk);
      check(!busy && !rd_req, "R5 R8", {name, " idle after outcome"}, int'(busy), 0);
      check(exp_pg.size() == 0, "R2 R3", {name, " requests left over"}, exp_pg.size(), 0);
      check(exp_commit.size() == 0, "R6 R7", {name, " commits left over"},
            exp_commit.size(), 0);
   endtask

   initial begin
      clear_flash();
      repeat (3) @(negedge clk);
      check(!busy && !rd_req && !done && !fatal, "R10", "idle after reset", int'(busy), 0);
      check(commit_addr == '0, "R10", "commit after reset", int'(commit_addr), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R2: clean three-block load with a short final block
      clear_flash();
      run("clean", 0, 187, 16'h1000);

      // R1 R3 R6: unaligned start, byte-0 marker skips a block
      clear_flash();
      mark0[10] = 1'b1;
      run("marker0", 96, 100, 16'h2000);

      // R4 R3: unreadable block skipped, byte-1 marker mid block
      clear_flash();
      for (int p = 0; p < 4; p++) unread[p] = 1'b1;
      mark1[6] = 1'b1;
      run("unreadable", 0, 64, 16'h3000);

      // R5: unreadable page in an unmarked block is fatal
      clear_flash();
      unread[5] = 1'b1;
      run("fatal", 0, 130, 16'h4000);

      // R3 R5: unreadable page then marker in one block is a skip
      clear_flash();
      unread[0] = 1'b1;
      mark0[1]  = 1'b1;
      run("err_then_mark", 0, 20, 16'h5000);

      // R8: zero length finishes without reads
      clear_flash();
      run("empty", 0, 0, 16'h6000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule